// File: doc/BRIEF.md
# Vector Sample to Pixel Mapper

This block sits between a dual-channel deflection digitizer and a shared frame-buffer arbiter in a vector-to-raster display converter. Every clock it may receive one X/Y deflection pair, 10 bits per axis, plus a valid strobe. Separately, and earlier, it receives the beam colour as three small per-channel codes. The digitizer has a fixed conversion latency. The colour inputs do not pass through it, so the block delays the colour by that many cycles to pair each colour with the position it belongs to.

Each accepted sample is mirrored on the horizontal axis and scaled by a configurable fixed-point factor. A configurable per-axis offset then places it inside the 640x480 active raster. The result becomes a write request made of a linear pixel address and a 12-bit colour word. A sample with all colour channels at zero marks a beam move with the beam off, and it writes nothing. A sample that lands outside the raster is discarded rather than wrapped.

The datapath never stalls. When the arbiter is busy, a single holding register keeps the newest request. Any older request it displaces is counted as dropped.

Top module: `vec_pixel_mapper`

## Requirements
- R1: While reset is asserted and right after it is released, `out_valid` is 0, `drop_cnt` is 0, and the colour delay line holds zeros.
- R2: The colour paired with a valid sample is the one presented on the colour inputs exactly ADC_LAT (default 6) clock cycles before that sample's `smp_valid` cycle.
- R3: The X coordinate is mirrored before any scaling: the value used is 1023 − `smp_x`. Y is not mirrored.
- R4: Each axis maps as floor(c × `cfg_scale` / 1024) + offset. The factor has 10 fractional bits. X uses `cfg_x_off` and Y uses `cfg_y_off`.
- R5: A sample whose mapped X is 640 or more, or whose mapped Y is 480 or more, produces no write. The values 639 and 479 are still written.
- R6: A sample whose aligned colour is zero on all three channels produces no write. Any single nonzero channel is enough to write.
- R7: `out_addr` = Y × 640 + X. `out_data` holds red in bits 11:8, green in bits 7:4 and blue in bits 3:0.
- R8: A sample presented before clock edge E appears on the outputs after edge E+2. With `out_ready` held high, one sample per clock is delivered, with no gaps and no loss.
- R9: While `out_valid` is 1 and `out_ready` is 0, the address and data on the outputs stay unchanged until a newer request arrives.
- R10: If a new request arrives while the held one is waiting (`out_valid` 1, `out_ready` 0), the new one replaces it and `drop_cnt` increases by exactly 1. In every other cycle `drop_cnt` keeps its value.
- R11: If a new request arrives in the same cycle as the held one is accepted, the new one takes its place and `drop_cnt` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | X/Y pair valid this cycle |
| smp_x | input | 10 | Horizontal deflection sample |
| smp_y | input | 10 | Vertical deflection sample |
| col_red | input | 4 | Red code, not yet delayed |
| col_grn | input | 4 | Green code, not yet delayed |
| col_blu | input | 4 | Blue code, not yet delayed |
| cfg_scale | input | 10 | Scale factor, value/1024 |
| cfg_x_off | input | 10 | Horizontal placement offset |
| cfg_y_off | input | 10 | Vertical placement offset |
| out_valid | output | 1 | Write request pending |
| out_ready | input | 1 | Arbiter accepts the request |
| out_addr | output | 19 | Linear pixel address |
| out_data | output | 12 | Pixel colour word |
| drop_cnt | output | 16 | Count of requests replaced before acceptance |

## Verification
The hardest case to reach is colour alignment. An off-by-one delay still produces plausible pixels, so the bench changes the colour it drives on every cycle. Its own history ring then picks the colour from ADC_LAT cycles back, and any slip shows up as wrong data. The replacement path is reached by holding `out_ready` low, parking one request, and then pushing a burst of back-to-back samples. Only the last sample of the burst must emerge, and the dropped count must equal the burst length. The raster edges are reached by choosing the factor and offsets so that mapped coordinates fall exactly on 639/640 and 479/480.

// File: rtl/vpm_pkg.sv
package vpm_pkg;

  // Horizontal reflection of a coordinate within a span of 2**width units.
  function automatic int unsigned mirror_coord(int unsigned c, int unsigned span);
    return span - 32'd1 - c;
  endfunction

  // Fixed-point scale with truncation, followed by a placement offset.
  function automatic int unsigned scale_coord(int unsigned c, int unsigned factor,
                                              int unsigned frac, int unsigned off);
    return ((c * factor) >> frac) + off;
  endfunction

  // Row-major linear address inside the active raster.
  function automatic int unsigned raster_addr(int unsigned x, int unsigned y,
                                              int unsigned width);
    return y * width + x;
  endfunction

endpackage

// File: rtl/color_align.sv
module color_align #(
  parameter int CW  = 12,
  parameter int LAT = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] din,
  output logic [CW-1:0] dout
);
  logic [CW-1:0] stage [LAT];

  for (genvar g = 0; g < LAT; g++) begin : g_tap
    if (g == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n) stage[g] <= '0;
        else        stage[g] <= din;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (!rst_n) stage[g] <= '0;
        else        stage[g] <= stage[g-1];
      end
    end
  end

  assign dout = stage[LAT-1];
endmodule

// File: rtl/coord_scaler.sv
module coord_scaler #(
  parameter int CW     = 10,
  parameter int SW     = 10,
  parameter int FRAC   = 10,
  parameter int LIMIT  = 640,
  parameter bit MIRROR = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] in_c,
  input  logic [SW-1:0] factor,
  input  logic [CW-1:0] offset,
  output logic [CW:0]   out_c,
  output logic          out_ok
);
  import vpm_pkg::*;

  localparam int unsigned SPAN = 32'd1 << CW;

  int unsigned eff;
  int unsigned mapped;

  if (MIRROR) begin : g_mirror
    always_comb eff = mirror_coord(32'(in_c), SPAN);
  end else begin : g_direct
    always_comb eff = 32'(in_c);
  end

  always_comb mapped = scale_coord(eff, 32'(factor), FRAC, 32'(offset));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_c  <= '0;
      out_ok <= 1'b0;
    end else begin
      out_c  <= (CW+1)'(mapped);
      out_ok <= (mapped < LIMIT);
    end
  end
endmodule

// File: rtl/addr_gen.sv
module addr_gen #(
  parameter int CW = 10,
  parameter int PW = 12,
  parameter int H  = 640,
  parameter int AW = 19
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [CW:0]   in_x,
  input  logic [CW:0]   in_y,
  input  logic          x_ok,
  input  logic          y_ok,
  input  logic [PW-1:0] in_col,
  output logic          s2_valid,
  output logic [AW-1:0] s2_addr,
  output logic [PW-1:0] s2_data
);
  import vpm_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s2_valid <= 1'b0;
      s2_addr  <= '0;
      s2_data  <= '0;
    end else begin
      s2_valid <= in_valid & x_ok & y_ok;
      s2_addr  <= AW'(raster_addr(32'(in_x), 32'(in_y), H));
      s2_data  <= in_col;
    end
  end
endmodule

// File: rtl/out_hold.sv
module out_hold #(
  parameter int AW = 19,
  parameter int PW = 12,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [AW-1:0] in_addr,
  input  logic [PW-1:0] in_data,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [AW-1:0] out_addr,
  output logic [PW-1:0] out_data,
  output logic [DW-1:0] drop_cnt,
  output logic          ev_overwrite
);
  logic stalled;

  assign stalled      = out_valid & ~out_ready;
  assign ev_overwrite = in_valid & stalled;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_data  <= '0;
      drop_cnt  <= '0;
    end else begin
      if (in_valid) begin
        out_valid <= 1'b1;
        out_addr  <= in_addr;
        out_data  <= in_data;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
      if (ev_overwrite) drop_cnt <= drop_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/vec_pixel_mapper.sv
module vec_pixel_mapper #(
  parameter int CW      = 10,
  parameter int CH_W    = 4,
  parameter int SW      = 10,
  parameter int FRAC    = 10,
  parameter int ADC_LAT = 6,
  parameter int H_ACT   = 640,
  parameter int V_ACT   = 480,
  parameter int DW      = 16,
  localparam int PW     = 3 * CH_W,
  localparam int AW     = $clog2(H_ACT * V_ACT)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            smp_valid,
  input  logic [CW-1:0]   smp_x,
  input  logic [CW-1:0]   smp_y,
  input  logic [CH_W-1:0] col_red,
  input  logic [CH_W-1:0] col_grn,
  input  logic [CH_W-1:0] col_blu,
  input  logic [SW-1:0]   cfg_scale,
  input  logic [CW-1:0]   cfg_x_off,
  input  logic [CW-1:0]   cfg_y_off,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [AW-1:0]   out_addr,
  output logic [PW-1:0]   out_data,
  output logic [DW-1:0]   drop_cnt
);
  // Named internal events for the checker
  logic          s1_valid;
  logic [PW-1:0] s1_col;
  logic          s2_valid;
  logic          ev_overwrite;

  logic [PW-1:0] col_now;
  logic [PW-1:0] col_aligned;
  logic          beam_lit;
  logic [CW:0]   sx, sy;
  logic          sx_ok, sy_ok;
  logic [AW-1:0] s2_addr;
  logic [PW-1:0] s2_data;

  assign col_now  = {col_red, col_grn, col_blu};
  assign beam_lit = |col_aligned;

  color_align #(.CW(PW), .LAT(ADC_LAT)) u_align (
    .clk(clk), .rst_n(rst_n), .din(col_now), .dout(col_aligned)
  );

  coord_scaler #(.CW(CW), .SW(SW), .FRAC(FRAC), .LIMIT(H_ACT), .MIRROR(1'b1)) u_sx (
    .clk(clk), .rst_n(rst_n), .in_c(smp_x), .factor(cfg_scale),
    .offset(cfg_x_off), .out_c(sx), .out_ok(sx_ok)
  );

  coord_scaler #(.CW(CW), .SW(SW), .FRAC(FRAC), .LIMIT(V_ACT), .MIRROR(1'b0)) u_sy (
    .clk(clk), .rst_n(rst_n), .in_c(smp_y), .factor(cfg_scale),
    .offset(cfg_y_off), .out_c(sy), .out_ok(sy_ok)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_col   <= '0;
    end else begin
      s1_valid <= smp_valid & beam_lit;
      s1_col   <= col_aligned;
    end
  end

  addr_gen #(.CW(CW), .PW(PW), .H(H_ACT), .AW(AW)) u_addr (
    .clk(clk), .rst_n(rst_n), .in_valid(s1_valid), .in_x(sx), .in_y(sy),
    .x_ok(sx_ok), .y_ok(sy_ok), .in_col(s1_col),
    .s2_valid(s2_valid), .s2_addr(s2_addr), .s2_data(s2_data)
  );

  out_hold #(.AW(AW), .PW(PW), .DW(DW)) u_hold (
    .clk(clk), .rst_n(rst_n), .in_valid(s2_valid), .in_addr(s2_addr),
    .in_data(s2_data), .out_ready(out_ready), .out_valid(out_valid),
    .out_addr(out_addr), .out_data(out_data), .drop_cnt(drop_cnt),
    .ev_overwrite(ev_overwrite)
  );
endmodule

// File: rtl/vpm_checker.sv
module vpm_checker #(
  parameter int AW    = 19,
  parameter int PW    = 12,
  parameter int DW    = 16,
  parameter int LIMIT = 307200
) (
  input logic          clk,
  input logic          rst_n,
  input logic          out_valid,
  input logic          out_ready,
  input logic [AW-1:0] out_addr,
  input logic [PW-1:0] out_data,
  input logic [DW-1:0] drop_cnt,
  input logic          s2_valid,
  input logic          ev_overwrite
);
  AST_ADDR_IN_RASTER: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (32'(out_addr) < LIMIT)); // R5
  AST_NO_BLANK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_data != '0)); // R6
  AST_REQ_REACHES_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    s2_valid |=> out_valid); // R8
  AST_HELD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !s2_valid) |=> (out_valid && $stable(out_addr) && $stable(out_data))); // R9
  AST_DROP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ev_overwrite |=> (drop_cnt == DW'($past(drop_cnt) + 1'b1))); // R10
  AST_DROP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && !out_ready && s2_valid) |=> $stable(drop_cnt)); // R11
endmodule

bind vec_pixel_mapper vpm_checker #(.AW(AW), .PW(PW), .DW(DW), .LIMIT(H_ACT * V_ACT)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_addr(out_addr), .out_data(out_data), .drop_cnt(drop_cnt),
  .s2_valid(s2_valid), .ev_overwrite(ev_overwrite)
);

// File: tb/tb_vec_pixel_mapper.sv
module tb_vec_pixel_mapper;
  localparam int LAT = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic [9:0]  smp_x = '0, smp_y = '0;
  logic [3:0]  col_red = '0, col_grn = '0, col_blu = '0;
  logic [9:0]  cfg_scale = 10'd480, cfg_x_off = 10'd80, cfg_y_off = 10'd0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [18:0] out_addr;
  logic [11:0] out_data;
  logic [15:0] drop_cnt;

  always #4 clk = ~clk;

  vec_pixel_mapper dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_x(smp_x), .smp_y(smp_y),
    .col_red(col_red), .col_grn(col_grn), .col_blu(col_blu),
    .cfg_scale(cfg_scale), .cfg_x_off(cfg_x_off), .cfg_y_off(cfg_y_off),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
    .out_data(out_data), .drop_cnt(drop_cnt)
  );

  int nchk = 0, nfail = 0;
  bit done = 1'b0;
  bit sb_en = 1'b1;
  int cyc = 0;
  logic [11:0] hist [16];
  logic [30:0] sbq [$];   // {addr, data}

  task automatic check(bit ok, string tag, longint act, longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Own statement of the mapping rules (R3, R4, R5, R6, R7)
  task automatic predict(int x, int y, logic [11:0] c);
    int mx, px, py;
    mx = 1023 - x;
    px = (mx * int'(cfg_scale)) / 1024 + int'(cfg_x_off);
    py = (y * int'(cfg_scale)) / 1024 + int'(cfg_y_off);
    if (c != 12'h000 && px < 640 && py < 480 && sb_en)
      sbq.push_back({19'(py * 640 + px), c});
  endtask

  // Driver: one clock per call; colour c is driven now, position pairs with colour from LAT steps back (R2)
  task automatic step(bit v, int x, int y, logic [11:0] c);
    @(negedge clk); #1;
    smp_valid = v;
    smp_x = 10'(x);
    smp_y = 10'(y);
    {col_red, col_grn, col_blu} = c;
    hist[cyc & 15] = c;
    if (v) predict(x, y, hist[(cyc - LAT) & 15]);
    cyc++;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, 0, 0, 12'h000);
  endtask

  // Monitor: handshake values as they stand at the coming edge
  initial begin
    forever begin
      @(negedge clk); #2;
      if (rst_n && out_valid && out_ready) begin
        if (sbq.size() == 0) begin
          check(1'b0, "R5/R6 unexpected write", {out_addr, out_data}, 0);
        end else begin
          logic [30:0] e;
          e = sbq.pop_front();
          check(out_addr == e[30:12], "R7 addr (R3 R4)", out_addr, e[30:12]);
          check(out_data == e[11:0], "R2 colour data", out_data, e[11:0]);
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) hist[i] = 12'h000;
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
    check(drop_cnt == 16'd0, "R1 drop_cnt in reset", drop_cnt, 0);
    @(negedge clk); #1 rst_n = 1'b1;
    idle(2);
    check(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);

    // R1: delay line starts cleared, so a sample right away is blank
    step(1'b1, 100, 100, 12'hFFF);
    idle(4);
    check(out_valid == 1'b0, "R1 cleared delay line blanks early sample", out_valid, 0);
    idle(4);

    // R8 latency: colour ahead, then one sample
    for (int i = 0; i < LAT; i++) step(1'b0, 0, 0, 12'hA5C);
    step(1'b1, 23, 200, 12'h000);
    idle(2);
    check(out_valid == 1'b0, "R8 not yet visible after E+1", out_valid, 0);
    idle(1);
    check(out_valid == 1'b1, "R8 visible after E+2", out_valid, 1);
    idle(6);

    // Stream: colour changes every cycle, one sample per clock (R2 R3 R4 R7 R8 R11)
    for (int i = 0; i < 26; i++)
      step(i >= LAT, (i * 37) % 1024, (i * 53 + 11) % 1024,
           {4'(i % 15 + 1), 4'(i * 3), 4'(i ^ 5)});
    idle(8);
    check(drop_cnt == 16'd0, "R11 no drops with ready high", drop_cnt, 0);

    // R6: black colour gives no write; blue-only does
    idle(LAT);
    for (int i = 0; i < 4; i++) step(1'b1, 300 + i, 300, 12'h000);
    idle(4);
    check(out_valid == 1'b0, "R6 black samples suppressed", out_valid, 0);
    for (int i = 0; i < LAT; i++) step(1'b0, 0, 0, 12'h001);
    step(1'b1, 500, 500, 12'h000);
    idle(3);
    check(out_valid == 1'b1, "R6 single channel writes", out_valid, 1);
    idle(4);

    // R5 boundaries: scale 1/2, x=1023 mirrors to 0
    cfg_scale = 10'd512; cfg_x_off = 10'd639; cfg_y_off = 10'd0;
    idle(2);
    for (int i = 0; i < LAT; i++) step(1'b0, 0, 0, 12'h3C7);
    step(1'b1, 1023, 958, 12'h3C7);  // x=639, y=479 kept
    idle(3);
    check(out_valid == 1'b1, "R5 edge 639/479 kept", out_valid, 1);
    for (int i = 0; i < LAT; i++) step(1'b0, 0, 0, 12'h3C7);
    step(1'b1, 1023, 960, 12'h3C7);  // y=480 dropped
    idle(3);
    check(out_valid == 1'b0, "R5 y=480 dropped", out_valid, 0);
    cfg_x_off = 10'd640;
    idle(2);
    for (int i = 0; i < LAT; i++) step(1'b0, 0, 0, 12'h3C7);
    step(1'b1, 1023, 100, 12'h3C7);  // x=640 dropped
    idle(3);
    check(out_valid == 1'b0, "R5 x=640 dropped", out_valid, 0);
    cfg_scale = 10'd480; cfg_x_off = 10'd80;
    idle(4);

    // R9 / R10: park a request, then overwrite it three times
    out_ready = 1'b0;
    for (int i = 0; i < LAT; i++) step(1'b0, 0, 0, 12'h210 + 12'(i));
    sb_en = 1'b0;
    step(1'b1, 40, 40, 12'h000);
    idle(6);
    begin
      logic [18:0] a0;
      a0 = out_addr;
      idle(4);
      check(out_valid == 1'b1 && out_addr == a0, "R9 held request stable", out_addr, a0);
    end
    check(drop_cnt == 16'd0, "R10 no drop while parked", drop_cnt, 0);
    for (int i = 0; i < LAT; i++) step(1'b0, 0, 0, 12'h700 + 12'(i));
    step(1'b1, 10, 20, 12'h000);
    step(1'b1, 11, 21, 12'h000);
    sb_en = 1'b1;
    step(1'b1, 12, 22, 12'h000);
    idle(4);
    check(drop_cnt == 16'd3, "R10 drop count after burst", drop_cnt, 3);
    out_ready = 1'b1;
    idle(6);
    check(drop_cnt == 16'd3, "R10 count steady after release", drop_cnt, 3);
    check(sbq.size() == 0, "R8 all expected writes delivered", sbq.size(), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule